// File: doc/BRIEF.md
# Serial Sampling-Converter Port Emulator

This block stands in for the digital side of a 16-bit successive-approximation converter's three-wire serial port. A host drives an active-low select and a data clock exactly as it would to the real converter, and the block answers on a serial data line with an output-enable that models the pin's high-impedance state. The result word comes from a parallel input, so the block can act as a loopback target when testing a host-side reader, or as an emulator fed by any on-chip source of samples.

Select and data clock are brought into the system clock domain through a short synchronizer, and the block acts on falling data-clock edges. After select falls, the first four falling edges form the sampling window. The fifth falling edge captures the parallel word, turns the output on and drives a single low null bit. The word is then sent most-significant bit first, and then mirrored back least-significant bit first without sending bit 0 a second time, after which the output turns itself off. Four status outputs, exactly one of them high at any time, report full shutdown, sampling, converting and analog power-down.

Top module: `adc_port_emulator`

## Requirements
- R1: While the synchronized select is high, `sdo_en` and `sdo` are low, `st_shutdown` is high, and toggling the data clock changes nothing.
- R2: After select falls, `st_sample` is high and `sdo_en` stays low through the first four falling data-clock edges.
- R3: On the fifth falling edge after select falls, `sdo_en` rises, `sdo` drives 0 (the null bit) and `st_convert` is high.
- R4: On falling edges 6 to 21, `sdo` carries result bits 15, 14, down to 0, one per edge, with `st_convert` high.
- R5: On falling edges 22 to 36, `sdo` carries result bits 1, 2, up to 15 (bit 0 is not repeated), with `st_analog_off` high; on edge 37 `sdo_en` falls.
- R6: Exactly one of `st_shutdown`, `st_sample`, `st_convert`, `st_analog_off` is high in every cycle out of reset.
- R7: Raising select at any point of a frame drops `sdo_en` and raises `st_shutdown` within three system clocks.
- R8: Once the mirrored word has ended, further falling edges leave `sdo_en` low and `st_analog_off` high until select goes high and then low again, which starts a fresh frame from sampling.
- R9: The result word is the value of `code_in` at the fifth falling edge; changes to `code_in` later in the frame do not alter the bits sent.
- R10: `sdo` is low whenever `sdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host; high means full shutdown |
| sclk | input | 1 | Data clock from the host; falling edges advance the frame |
| code_in | input | 16 | Parallel result word, captured at the end of sampling |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Output enable; low models high impedance |
| st_shutdown | output | 1 | Full shutdown (select high) |
| st_sample | output | 1 | Sampling window |
| st_convert | output | 1 | Null bit and most-significant-first phase |
| st_analog_off | output | 1 | Conversion done, digital side still active |

## Verification
A wrong falling-edge count or bit index shows up at the very next falling edge as a wrong `sdo` value or a misplaced enable, so the bench compares `sdo`, `sdo_en` and all four status flags after every falling edge of every frame. A wrong captured word appears on the first data bit after the null bit, and mid-frame changes to `code_in` expose a capture that is not held. A frame that fails to end or restart shows within three system clocks of a select rise, or as a live enable after edge 37.

// File: rtl/adc_port_emulator.sv
module adc_port_emulator #(
  parameter int W           = 16,
  parameter int HOLD_FALLS  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] code_in,
  output logic         sdo,
  output logic         sdo_en,
  output logic         st_shutdown,
  output logic         st_sample,
  output logic         st_convert,
  output logic         st_analog_off
);
  localparam int IW = $clog2(W);
  localparam int HW = $clog2(HOLD_FALLS + 1);

  typedef enum logic [2:0] {SHUT, SAMPLE, NULLB, MSBF, LSBF, DONE} state_t;

  state_t state;
  logic [SYNC_STAGES-1:0] cs_pipe, ck_pipe;
  logic          cs_s, ck_s, ck_d, fall;
  logic [HW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [W-1:0]  code_q;

  assign cs_s = cs_pipe[SYNC_STAGES-1];
  assign ck_s = ck_pipe[SYNC_STAGES-1];
  assign fall = ck_d & ~ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe <= '1;
      ck_pipe <= '0;
      ck_d    <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      ck_pipe <= {ck_pipe[SYNC_STAGES-2:0], sclk};
      ck_d    <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SHUT;
      cnt    <= '0;
      idx    <= '0;
      code_q <= '0;
    end else if (cs_s) begin
      state <= SHUT;
    end else begin
      case (state)
        SHUT: begin
          state <= SAMPLE;
          cnt   <= '0;
        end
        SAMPLE: if (fall) begin
          if (cnt == HW'(HOLD_FALLS - 1)) begin
            state  <= NULLB;
            code_q <= code_in;
          end else cnt <= cnt + 1'b1;
        end
        NULLB: if (fall) begin
          state <= MSBF;
          idx   <= IW'(W - 1);
        end
        MSBF: if (fall) begin
          if (idx == '0) begin
            state <= LSBF;
            idx   <= IW'(1);
          end else idx <= idx - 1'b1;
        end
        LSBF: if (fall) begin
          if (idx == IW'(W - 1)) state <= DONE;
          else idx <= idx + 1'b1;
        end
        default: state <= DONE;
      endcase
    end
  end

  assign sdo_en        = (state == NULLB) || (state == MSBF) || (state == LSBF);
  assign sdo           = ((state == MSBF) || (state == LSBF)) && code_q[idx];
  assign st_shutdown   = (state == SHUT);
  assign st_sample     = (state == SAMPLE);
  assign st_convert    = (state == NULLB) || (state == MSBF);
  assign st_analog_off = (state == LSBF) || (state == DONE);

  // R6
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_shutdown, st_sample, st_convert, st_analog_off}) == 1);

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  // R7
  cs_high_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st_shutdown && !sdo_en));

  // R3
  null_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> (!sdo && st_convert && $past(st_sample)));

  // R9
  word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en)) |-> $stable(code_q));

  // R8
  done_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_analog_off && !sdo_en && !cs_s) |=> (!sdo_en && st_analog_off));
endmodule

// File: tb/adc_port_emulator_test.sv
`timescale 1ns/1ps
module adc_port_emulator_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [15:0] code_in = '0;
  logic sdo, sdo_en, st_shutdown, st_sample, st_convert, st_analog_off;
  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  adc_port_emulator uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .code_in(code_in),
    .sdo(sdo), .sdo_en(sdo_en), .st_shutdown(st_shutdown), .st_sample(st_sample),
    .st_convert(st_convert), .st_analog_off(st_analog_off));

  // expected {en, bit, shutdown, sample, convert, analog_off} after falling edge k of a frame
  function automatic logic [5:0] exp_after(input logic [15:0] c, input int k);
    if (k < 5)       return 6'b00_0100;
    else if (k == 5) return 6'b10_0010;
    else if (k <= 21) return {1'b1, c[21-k], 4'b0010};
    else if (k <= 36) return {1'b1, c[k-21], 4'b0001};
    else             return 6'b00_0001;
  endfunction

  task automatic cmp(input logic [5:0] exp, input string req, input int k);
    logic [5:0] act;
    act = {sdo_en, sdo, st_shutdown, st_sample, st_convert, st_analog_off};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: got %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic string req_of(input int k);
    if (k < 5) return "R2";
    if (k == 5) return "R3";
    if (k <= 21) return "R4";
    if (k <= 36) return "R5";
    return "R8";
  endfunction

  // runs one frame with nfalls falling edges, optionally scrambling code_in after capture
  task automatic frame(input logic [15:0] c, input int nfalls, input bit scramble);
    code_in = c;
    cs_n = 1'b0;
    wait_clks(6);
    cmp(6'b00_0100, "R2", 0);
    for (int k = 1; k <= nfalls; k++) begin
      sclk = 1'b1; wait_clks(8);
      sclk = 1'b0; wait_clks(8);
      cmp(exp_after(c, k), req_of(k), k);
      if (k >= 5 && scramble) code_in = 16'($urandom);
      if (k == 5 && scramble) cmp(exp_after(c, k), "R9", k);
    end
    cs_n = 1'b1;
    wait_clks(3);
    cmp(6'b00_1000, "R7", nfalls);
    wait_clks(3);
  endtask

  initial begin
    void'($urandom(32'd1357));
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    cmp(6'b00_1000, "R1", 0);
    // R1: clock activity with select high has no effect
    for (int i = 0; i < 10; i++) begin
      sclk = ~sclk; wait_clks(6);
      cmp(6'b00_1000, "R1", i);
    end
    sclk = 1'b0; wait_clks(4);
    // directed corner words, full frames plus trailing edges (R4 R5 R8)
    frame(16'h0000, 40, 0);
    frame(16'hFFFF, 40, 0);
    frame(16'h8000, 38, 0);
    frame(16'h7FFF, 38, 0);
    frame(16'h0001, 37, 0);
    // R9: input changes during the frame
    frame(16'hA5C3, 37, 1);
    // R7: short cycles at chosen points
    frame(16'h1234, 3, 0);
    frame(16'h1234, 5, 0);
    frame(16'h1234, 12, 0);
    frame(16'h1234, 24, 0);
    // random words and random abort points
    for (int f = 0; f < 40; f++) begin
      int nf;
      nf = (f % 3 == 0) ? int'($urandom_range(1, 40)) : 38;
      frame(16'($urandom), nf, f[0]);
    end
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_clks(150000);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule